// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight level-sensitive interrupt lines and presents one interrupt request to the processor. The processor reaches it through a two-address byte port. Address 0 accepts command bytes and reads back a status register. Address 1 carries configuration words and the mask register. After reset the controller waits for an initialization sequence. That sequence fixes the vector base, the cascade word and the end-of-interrupt mode. Only then does it forward requests.

Each cycle the inputs are sampled into the request register. A sampled request is eligible when its mask bit is clear and no in-service bit of equal or higher priority is set. Priority is fixed, with line 0 highest. While an eligible request exists, the interrupt output stays high. A one-cycle acknowledge pulse latches the highest eligible line into the in-service register and loads the vector output with base plus line number. If nothing is eligible at acknowledge, the controller answers with the vector for line 7 and leaves the in-service register unchanged, so software can tell a spurious interrupt from a real one. A master or slave strap selects how the cascade word is read.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF and the request and in-service registers are cleared. Command-address reads return the request register, `vec_out` is 0x00, and `int_req` stays low until initialization completes, even when a request is present and unmasked.
- R2: A command write with bit 4 set starts initialization. The next three data writes are taken in order. The first is the vector base, and its low 3 bits are dropped. The second is the cascade word: `cas_word` shows it whole on a master and as its low 3 bits on a slave (`cfg_slave`=1). The third is the mode word.
- R3: On acknowledge of a real request on line n, `vec_out` becomes base + n on the following clock edge.
- R4: Priority is fixed: among eligible requests, the one with the lowest line number is acknowledged.
- R5: Outside initialization, a data write loads the mask register and a data-address read returns it. A mask bit of 1 blocks its line from `int_req` and from acknowledge.
- R6: A request is not forwarded while an in-service bit at its own or a higher-priority line is set. Requests of higher priority still are.
- R7: Command byte 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R8: Command byte 0x0A selects the request register and 0x0B the in-service register for command-address reads. The selection persists across other writes until it is changed.
- R9: When bit 1 of the mode word is set, acknowledge returns the vector but sets no in-service bit.
- R10: An acknowledge with no eligible request returns vector base + 7 and sets no in-service bit. This holds even when line 7 is masked.
- R11: Inputs are level-sensitive. When a request line drops, `int_req` falls one clock edge later unless another eligible request remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for the current `bus_addr` |
| cfg_slave | input | 1 | 1 = device operates as a cascaded slave |
| irq_in | input | 8 | Level-sensitive interrupt request lines |
| ack_pulse | input | 1 | One-cycle interrupt acknowledge |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector latched by the last acknowledge |
| cas_word | output | 8 | Programmed cascade configuration |

## Verification
The hardest situation to reach is the spurious acknowledge. It needs an acknowledge to arrive while nothing is eligible, which means a request that was withdrawn or masked after `int_req` could have been seen. The bench reaches it two ways. It pulses acknowledge with all lines low, and it raises every line under a mask of 0xFF, which also covers a masked line 7. It then reads the in-service register through the 0x0B selection to confirm that no bit was set. The in-service blocking case is reached by holding one line in service and then raising lines of higher, equal and lower priority together.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_BASE = 3'd1,
    ST_CASC = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } cfg_state_e;

  localparam int unsigned INIT_BIT   = 4;
  localparam logic [2:0]  EOI_TAG    = 3'b011;
  localparam logic [7:0]  SEL_REQ    = 8'h0A;
  localparam logic [7:0]  SEL_SVC    = 8'h0B;
  localparam int unsigned AUTO_BIT   = 1;
endpackage

// File: rtl/pic_cfg.sv
`timescale 1ns/1ps
module pic_cfg
  import pic_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned ID_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          slave_mode,
  output logic          ready,
  output logic [DW-1:0] vbase,
  output logic [DW-1:0] casc,
  output logic          auto_eoi,
  output logic [DW-1:0] mask,
  output logic          svc_sel,
  output logic          init_pulse,
  output logic          eoi_valid,
  output logic [ID_W-1:0] eoi_id
);
  localparam logic [DW-1:0] LOW_BITS = DW'((1 << ID_W) - 1);

  cfg_state_e st_q, st_d;
  logic [DW-1:0] base_q, base_d, casc_q, casc_d, mask_q, mask_d;
  logic          aeoi_q, aeoi_d, sel_q, sel_d;

  always_comb begin
    st_d       = st_q;
    base_d     = base_q;
    casc_d     = casc_q;
    aeoi_d     = aeoi_q;
    mask_d     = mask_q;
    sel_d      = sel_q;
    init_pulse = 1'b0;
    eoi_valid  = 1'b0;
    eoi_id     = wdata[ID_W-1:0];
    if (wr_en) begin
      if (!addr) begin
        if (wdata[INIT_BIT]) begin
          st_d       = ST_BASE;
          sel_d      = 1'b0;
          init_pulse = 1'b1;
        end else if (wdata[7:5] == EOI_TAG) begin
          eoi_valid = 1'b1;
        end else if (wdata == SEL_REQ) begin
          sel_d = 1'b0;
        end else if (wdata == SEL_SVC) begin
          sel_d = 1'b1;
        end
      end else begin
        case (st_q)
          ST_BASE: begin
            base_d = wdata & ~LOW_BITS;
            st_d   = ST_CASC;
          end
          ST_CASC: begin
            casc_d = slave_mode ? (wdata & LOW_BITS) : wdata;
            st_d   = ST_MODE;
          end
          ST_MODE: begin
            aeoi_d = wdata[AUTO_BIT];
            st_d   = ST_RUN;
          end
          default: mask_d = wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT;
      base_q <= '0;
      casc_q <= '0;
      aeoi_q <= 1'b0;
      mask_q <= '1;
      sel_q  <= 1'b0;
    end else if (wr_en) begin
      st_q   <= st_d;
      base_q <= base_d;
      casc_q <= casc_d;
      aeoi_q <= aeoi_d;
      mask_q <= mask_d;
      sel_q  <= sel_d;
    end
  end

  assign ready    = (st_q == ST_RUN);
  assign vbase    = base_q;
  assign casc     = casc_q;
  assign auto_eoi = aeoi_q;
  assign mask     = mask_q;
  assign svc_sel  = sel_q;

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && st_q == ST_RUN) |=> (mask == $past(wdata)));

  // R2
  init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[INIT_BIT]) |=> (st_q == ST_BASE));
endmodule

// File: rtl/pic_prio.sv
`timescale 1ns/1ps
module pic_prio #(
  parameter int unsigned N    = 8,
  parameter int unsigned ID_W = 3
) (
  input  logic [N-1:0]    irr,
  input  logic [N-1:0]    isr,
  input  logic [N-1:0]    mask,
  output logic            any,
  output logic [ID_W-1:0] gid
);
  logic [N-1:0] svc_upto;
  logic [N-1:0] elig;

  assign svc_upto[0] = isr[0];
  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_upto
      assign svc_upto[g] = svc_upto[g-1] | isr[g];
    end
  endgenerate

  assign elig = irr & ~mask & ~svc_upto;

  always_comb begin
    any = 1'b0;
    gid = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        gid = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
`timescale 1ns/1ps
module pic_core #(
  parameter int unsigned N    = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_in,
  input  logic            ack,
  input  logic            live,
  input  logic [ID_W-1:0] gid,
  input  logic            eoi_valid,
  input  logic [ID_W-1:0] eoi_id,
  input  logic            init_clr,
  input  logic            auto_eoi,
  input  logic [DW-1:0]   vbase,
  output logic [N-1:0]    irr,
  output logic [N-1:0]    isr,
  output logic [DW-1:0]   vec
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(N - 1);

  logic [N-1:0]  irr_q, isr_q, isr_d, set_m, clr_m;
  logic [DW-1:0] vec_q, vec_d;
  logic [ID_W-1:0] sel_id;

  always_comb begin
    set_m  = (ack && live && !auto_eoi) ? (N'(1) << gid) : '0;
    clr_m  = eoi_valid ? (N'(1) << eoi_id) : '0;
    isr_d  = init_clr ? '0 : ((isr_q & ~clr_m) | set_m);
    sel_id = live ? gid : LAST_ID;
    vec_d  = vbase | {{(DW-ID_W){1'b0}}, sel_id};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      vec_q <= '0;
    end else begin
      irr_q <= irq_in;
      isr_q <= isr_d;
      if (ack) vec_q <= vec_d;
    end
  end

  assign irr = irr_q;
  assign isr = isr_q;
  assign vec = vec_q;

  // R10
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !live) |=> (vec_q[ID_W-1:0] == LAST_ID && !(isr_q[N-1] && !$past(isr_q[N-1]))));

  // R9
  aeoi_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_eoi) |=> ((isr_q & ~$past(isr_q)) == '0));

  // R6
  grant_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && live) |-> ((isr_q & ((N'(2) << gid) - N'(1))) == '0));

  // R7
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack && !init_clr) |=> !isr_q[$past(eoi_id)]);

  // R3
  real_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && live) |=> (vec_q[ID_W-1:0] == $past(gid)));

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q & ~$past(isr_q)) <= 1);
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cfg_slave,
  input  logic [N_LINES-1:0] irq_in,
  input  logic          ack_pulse,
  output logic          int_req,
  output logic [DW-1:0] vec_out,
  output logic [DW-1:0] cas_word
);
  localparam int unsigned ID_W = $clog2(N_LINES);

  logic            ready, auto_eoi, svc_sel, init_pulse, eoi_valid, any, live;
  logic [DW-1:0]   vbase, mask;
  logic [ID_W-1:0] eoi_id, gid;
  logic [N_LINES-1:0] irr, isr;

  pic_cfg #(.DW(DW), .ID_W(ID_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .slave_mode(cfg_slave), .ready(ready),
    .vbase(vbase), .casc(cas_word), .auto_eoi(auto_eoi), .mask(mask),
    .svc_sel(svc_sel), .init_pulse(init_pulse), .eoi_valid(eoi_valid),
    .eoi_id(eoi_id)
  );

  pic_prio #(.N(N_LINES), .ID_W(ID_W)) u_prio (
    .irr(irr), .isr(isr), .mask(mask[N_LINES-1:0]), .any(any), .gid(gid)
  );

  assign live    = ready & any;
  assign int_req = live;

  pic_core #(.N(N_LINES), .DW(DW), .ID_W(ID_W)) u_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack_pulse),
    .live(live), .gid(gid), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
    .init_clr(init_pulse), .auto_eoi(auto_eoi), .vbase(vbase),
    .irr(irr), .isr(isr), .vec(vec_out)
  );

  always_comb begin
    if (bus_addr) bus_rdata = mask;
    else          bus_rdata = svc_sel ? DW'(isr) : DW'(irr);
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_req);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cfg_slave = 1'b0;
  logic [7:0] irq_in = 8'h00;
  logic       ack_pulse = 1'b0;
  logic       int_req;
  logic [7:0] vec_out;
  logic [7:0] cas_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_slave(cfg_slave),
    .irq_in(irq_in), .ack_pulse(ack_pulse), .int_req(int_req),
    .vec_out(vec_out), .cas_word(cas_word)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ack();
    ack_pulse = 1'b1;
    @(negedge clk);
    ack_pulse = 1'b0;
  endtask

  task automatic read_svc(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 8'h00) lowest = 7;
  endfunction

  task automatic init(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
    wr(1'b0, 8'h11);
    wr(1'b1, b);
    wr(1'b1, c);
    wr(1'b1, m);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pat, m;
    int idx;
    step(); step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 int_req", {7'd0, int_req}, 8'h00);
    rd(1'b1, d); check("R1 mask", d, 8'hFF);
    rd(1'b0, d); check("R1 irr", d, 8'h00);
    check("R1 vec", vec_out, 8'h00);
    wr(1'b1, 8'h00);
    irq_in = 8'h01; step();
    check("R1 waits for init", {7'd0, int_req}, 8'h00);
    rd(1'b0, d); check("R8 default request read", d, 8'h01);
    irq_in = 8'h00;

    // R2 master init; base low bits dropped
    init(8'h23, 8'h04, 8'h01);
    check("R2 cascade master", cas_word, 8'h04);
    wr(1'b1, 8'h00);

    // R3 R4 R11 exhaustive request patterns
    for (int p = 0; p < 256; p++) begin
      pat = 8'(p);
      irq_in = pat; step();
      check("R11 int_req level", {7'd0, int_req}, {7'd0, pat != 8'h00});
      ack();
      idx = lowest(pat);
      check("R3 R4 vector", vec_out, 8'h20 + 8'(idx));
      read_svc(d);
      check("R10 R4 in-service", d, (pat != 8'h00) ? (8'h01 << idx) : 8'h00);
      if (pat != 8'h00) begin
        wr(1'b0, 8'h60 + 8'(idx));
        read_svc(d);
        check("R7 eoi clears", d, 8'h00);
      end
      irq_in = 8'h00;
    end

    // R5 R10 exhaustive mask with all lines raised
    irq_in = 8'hFF; step();
    for (int k = 0; k < 256; k++) begin
      m = 8'(k);
      wr(1'b1, m);
      rd(1'b1, d); check("R5 mask readback", d, m);
      check("R5 masked int_req", {7'd0, int_req}, {7'd0, m != 8'hFF});
      ack();
      idx = lowest(~m);
      check("R5 R10 vector", vec_out, 8'h20 + 8'(idx));
      read_svc(d);
      check("R10 R5 in-service", d, (m != 8'hFF) ? (8'h01 << idx) : 8'h00);
      if (m != 8'hFF) wr(1'b0, 8'h60 + 8'(idx));
    end
    irq_in = 8'h00;

    // R6 in-service blocking
    wr(1'b1, 8'h00);
    irq_in = 8'h08; step();
    ack();
    irq_in = 8'h18; step();
    check("R6 blocked equal/lower", {7'd0, int_req}, 8'h00);
    irq_in = 8'h1C; step();
    check("R6 higher passes", {7'd0, int_req}, 8'h01);
    ack();
    check("R6 vector", vec_out, 8'h22);
    read_svc(d); check("R6 nested", d, 8'h0C);
    wr(1'b0, 8'h62);
    read_svc(d); check("R7 only bit 2", d, 8'h08);
    wr(1'b0, 8'h63);
    read_svc(d); check("R7 bit 3", d, 8'h00);
    irq_in = 8'h00;

    // R8 read select persistence
    wr(1'b0, 8'h0A);
    irq_in = 8'h05; step();
    rd(1'b0, d); check("R8 request read", d, 8'h05);
    wr(1'b1, 8'h33);
    rd(1'b0, d); check("R8 persists", d, 8'h05);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R8 service read", d, 8'h00);
    irq_in = 8'h00;
    wr(1'b1, 8'h00);

    // R11 withdrawn request
    irq_in = 8'h40; step();
    check("R11 raised", {7'd0, int_req}, 8'h01);
    irq_in = 8'h00; step();
    check("R11 dropped", {7'd0, int_req}, 8'h00);

    // R10 spurious with line 7 masked and no request
    wr(1'b1, 8'hFF);
    ack();
    check("R10 masked spurious", vec_out, 8'h27);
    read_svc(d); check("R10 no in-service", d, 8'h00);
    wr(1'b1, 8'h00);

    // R9 automatic end of interrupt
    init(8'h40, 8'h04, 8'h03);
    irq_in = 8'h02; step();
    ack();
    check("R9 vector", vec_out, 8'h41);
    read_svc(d); check("R9 no in-service", d, 8'h00);
    check("R9 still requesting", {7'd0, int_req}, 8'h01);
    irq_in = 8'h00;

    // R2 slave identity
    cfg_slave = 1'b1;
    init(8'h28, 8'hFA, 8'h01);
    check("R2 cascade slave", cas_word, 8'h02);
    irq_in = 8'h01; step();
    ack();
    check("R2 R3 slave vector", vec_out, 8'h28);
    irq_in = 8'h00;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule